// File: doc/BRIEF.md
# Boot Flash Failover Watchdog

This block protects processor start-up against a primary boot flash that is blank or holds a damaged boot block. Each time a reset reaches the payload processor, the block starts a countdown. Boot firmware on the host is expected to stop that countdown with a register write once it has started up correctly. If the countdown runs out first, the block assumes the primary device is unusable and fails over. It removes payload power, moves the boot flash select to the secondary device, waits for that change to settle, and then restores power so the processor starts again from the backup image.

The countdown is measured in prescaled ticks of the system clock. Its length is held in a register that software can write. The power-off interval and the settle interval are parameters, also counted in ticks. A sticky status flag records that a failover took place. If the countdown expires again while the secondary device is already selected, the block raises an error flag and does nothing else: it does not swap again and does not cycle power. The flash select stays on the secondary device until software writes it back.

Top module: `boot_failover_wdog`

## Requirements
- R1: While reset is applied and right after it, payload power enable is 1, flash select is 0 (primary), the countdown is armed, and busy, failover and error are all 0. The countdown starts at the reset timeout value, TMO_RESET ticks.
- R2: A rising edge on any bit of the reset-source input, seen while no recovery is running, arms the countdown and loads it with the timeout register. Expiry happens at the clock edge exactly timeout × PRESCALE cycles after the loading edge. A new edge while the countdown is armed reloads it.
- R3: A write to address 0 with data bit 0 set disarms the countdown. After that, power and flash select do not change, however long the block is left alone.
- R4: At the expiry edge, payload power enable drops to 0 and busy rises. Power stays off for OFF_TICKS ticks.
- R5: At the end of the power-off interval, flash select goes to 1 (secondary) and the sticky failover flag is set. Power stays off for SETTLE_TICKS more ticks.
- R6: At the end of the settle interval, power enable returns to 1, busy falls, and the countdown is rearmed with the timeout register.
- R7: Reset-source edges that arrive while busy is high are ignored. The sequence keeps its timing and the countdown stays disarmed until power-on.
- R8: The failover flag stays set until a write to address 0 with data bit 1 set. The error flag stays set until a write to address 0 with data bit 2 set.
- R9: If the countdown expires while flash select is already 1, the error flag is set and the countdown is disarmed. Power stays on and flash select does not change.
- R10: A write to address 2 sets flash select to data bit 0 when busy is low. The same write is ignored while busy is high.
- R11: Address 1 holds the timeout in ticks and resets to TMO_RESET. A written value of 0 is stored as 1. A new value takes effect at the next load, not on a countdown already running.
- R12: The tick prescaler restarts its phase on every load of the countdown, so an externally armed countdown times exactly timeout × PRESCALE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_src_i | input | NUM_SRC | Payload reset sources, active high; a rising edge on any bit arms the countdown |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 timeout, 2 flash select |
| reg_wdata_i | input | TMO_W | Register write data |
| pwr_en_o | output | 1 | Payload power enable |
| flash_sel_o | output | 1 | Boot flash select, 0 primary and 1 secondary |
| armed_o | output | 1 | Countdown is running |
| busy_o | output | 1 | Recovery sequence in progress |
| failover_o | output | 1 | Sticky flag: a failover took place |
| error_o | output | 1 | Sticky flag: expiry happened with the secondary already selected |

## Verification
The bench goes after these corner cases:
- A disarm write that lands on the same edge as expiry. A design that gives expiry priority would start a power cycle the firmware had already cancelled.
- Reset-source edges and flash-select writes issued in the middle of a recovery. A design that honours them would reload the countdown while power is off, or undo the swap before the processor restarts.
- A second expiry on the secondary device. A design that swaps blindly would flip back to the damaged primary flash.
- A timeout register changed while a countdown is running, and a timeout written as zero. Wrong handling shows up as an expiry at the wrong edge, or as a countdown that never ends.

// File: rtl/bfw_pkg.sv
package bfw_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PWR_OFF = 2'd1,
        SEQ_SETTLE  = 2'd2
    } seq_state_t;

    typedef enum logic {
        FLASH_PRIMARY   = 1'b0,
        FLASH_SECONDARY = 1'b1
    } flash_sel_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TMO  = 2'd1;
    localparam logic [1:0] ADDR_FSEL = 2'd2;

    typedef struct packed {
        logic disarm;
        logic clr_fail;
        logic clr_err;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic we,
                                              input logic [1:0] addr,
                                              input logic [2:0] bits);
        ctrl_cmd_t c;
        c.disarm   = we && (addr == ADDR_CTRL) && bits[0];
        c.clr_fail = we && (addr == ADDR_CTRL) && bits[1];
        c.clr_err  = we && (addr == ADDR_CTRL) && bits[2];
        return c;
    endfunction

endpackage

// File: rtl/bfw_prescaler.sv
module bfw_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/bfw_countdown.sv
module bfw_countdown #(
    parameter int TMO_W     = 16,
    parameter int TMO_RESET = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             disarm_i,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic             armed_o,
    output logic             expire_o
);
    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    logic [TMO_W-1:0] cnt_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
            cnt_q   <= TMO_W'(TMO_RESET);
        end else if (load_i) begin
            armed_q <= 1'b1;
            cnt_q   <= timeout_i;
        end else if (disarm_i) begin
            armed_q <= 1'b0;
        end else if (armed_q && tick_i) begin
            if (cnt_q == ONE) begin
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign armed_o  = armed_q;
    assign expire_o = armed_q && tick_i && !load_i && !disarm_i && (cnt_q == ONE);
endmodule

// File: rtl/bfw_sequencer.sv
module bfw_sequencer
    import bfw_pkg::*;
#(
    parameter int OFF_TICKS    = 8,
    parameter int SETTLE_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       expire_i,
    input  logic       tick_i,
    input  flash_sel_t sel_i,
    output logic       pwr_en_o,
    output logic       busy_o,
    output logic       swap_o,
    output logic       rearm_o,
    output logic       err_o
);
    localparam int MAXT = (OFF_TICKS > SETTLE_TICKS) ? OFF_TICKS : SETTLE_TICKS;
    localparam int SW   = $clog2(MAXT + 1);
    localparam logic [SW-1:0] OFF_LAST    = SW'(OFF_TICKS - 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_TICKS - 1);

    seq_state_t    state_q;
    logic [SW-1:0] step_q;
    logic          pwr_q;
    logic          off_done;
    logic          settle_done;

    assign off_done    = (state_q == SEQ_PWR_OFF) && tick_i && (step_q == OFF_LAST);
    assign settle_done = (state_q == SEQ_SETTLE)  && tick_i && (step_q == SETTLE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            step_q  <= '0;
            pwr_q   <= 1'b1;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (expire_i && (sel_i == FLASH_PRIMARY)) begin
                        state_q <= SEQ_PWR_OFF;
                        step_q  <= '0;
                        pwr_q   <= 1'b0;
                    end
                end
                SEQ_PWR_OFF: begin
                    if (off_done) begin
                        state_q <= SEQ_SETTLE;
                        step_q  <= '0;
                    end else if (tick_i) begin
                        step_q <= step_q + 1'b1;
                    end
                end
                SEQ_SETTLE: begin
                    if (settle_done) begin
                        state_q <= SEQ_IDLE;
                        step_q  <= '0;
                        pwr_q   <= 1'b1;
                    end else if (tick_i) begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    pwr_q   <= 1'b1;
                end
            endcase
        end
    end

    assign pwr_en_o = pwr_q;
    assign busy_o   = (state_q != SEQ_IDLE);
    assign swap_o   = off_done;
    assign rearm_o  = settle_done;
    assign err_o    = (state_q == SEQ_IDLE) && expire_i && (sel_i == FLASH_SECONDARY);
endmodule

// File: rtl/bfw_regs.sv
module bfw_regs
    import bfw_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int TMO_RESET = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [1:0]       addr_i,
    input  logic [TMO_W-1:0] wdata_i,
    input  logic             busy_i,
    input  logic             swap_i,
    input  logic             err_i,
    output ctrl_cmd_t        cmd_o,
    output logic [TMO_W-1:0] timeout_o,
    output flash_sel_t       sel_o,
    output logic             failover_o,
    output logic             error_o
);
    logic [TMO_W-1:0] tmo_q;
    flash_sel_t       sel_q;
    logic             fail_q;
    logic             err_q;

    assign cmd_o = decode_ctrl(we_i, addr_i, wdata_i[2:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmo_q <= TMO_W'(TMO_RESET);
        end else if (we_i && (addr_i == ADDR_TMO)) begin
            tmo_q <= (wdata_i == '0) ? TMO_W'(1) : wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= FLASH_PRIMARY;
        end else if (swap_i) begin
            sel_q <= FLASH_SECONDARY;
        end else if (we_i && (addr_i == ADDR_FSEL) && !busy_i) begin
            sel_q <= flash_sel_t'(wdata_i[0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (swap_i) begin
                fail_q <= 1'b1;
            end else if (cmd_o.clr_fail) begin
                fail_q <= 1'b0;
            end
            if (err_i) begin
                err_q <= 1'b1;
            end else if (cmd_o.clr_err) begin
                err_q <= 1'b0;
            end
        end
    end

    assign timeout_o  = tmo_q;
    assign sel_o      = sel_q;
    assign failover_o = fail_q;
    assign error_o    = err_q;
endmodule

// File: rtl/boot_failover_wdog.sv
module boot_failover_wdog
    import bfw_pkg::*;
#(
    parameter int NUM_SRC      = 3,
    parameter int TMO_W        = 16,
    parameter int TMO_RESET    = 1000,
    parameter int PRESCALE     = 16,
    parameter int OFF_TICKS    = 8,
    parameter int SETTLE_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] rst_src_i,
    input  logic               reg_we_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [TMO_W-1:0]   reg_wdata_i,
    output logic               pwr_en_o,
    output logic               flash_sel_o,
    output logic               armed_o,
    output logic               busy_o,
    output logic               failover_o,
    output logic               error_o
);
    logic [NUM_SRC-1:0] src_q;
    logic               ext_arm;
    logic               load;
    logic               tick;
    logic               expire;
    logic               swap;
    logic               rearm;
    logic               err_evt;
    logic               busy;
    logic [TMO_W-1:0]   timeout;
    flash_sel_t         sel;
    ctrl_cmd_t          cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
        end else begin
            src_q <= rst_src_i;
        end
    end

    assign ext_arm = (|(rst_src_i & ~src_q)) && !busy;
    assign load    = ext_arm || rearm;

    bfw_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (load),
        .tick_o (tick)
    );

    bfw_countdown #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .disarm_i  (cmd.disarm),
        .tick_i    (tick),
        .timeout_i (timeout),
        .armed_o   (armed_o),
        .expire_o  (expire)
    );

    bfw_sequencer #(.OFF_TICKS(OFF_TICKS), .SETTLE_TICKS(SETTLE_TICKS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .expire_i (expire),
        .tick_i   (tick),
        .sel_i    (sel),
        .pwr_en_o (pwr_en_o),
        .busy_o   (busy),
        .swap_o   (swap),
        .rearm_o  (rearm),
        .err_o    (err_evt)
    );

    bfw_regs #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .busy_i     (busy),
        .swap_i     (swap),
        .err_i      (err_evt),
        .cmd_o      (cmd),
        .timeout_o  (timeout),
        .sel_o      (sel),
        .failover_o (failover_o),
        .error_o    (error_o)
    );

    assign busy_o      = busy;
    assign flash_sel_o = sel;
endmodule

// File: rtl/bfw_checker.sv
module bfw_checker
    import bfw_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we_i,
    input logic [1:0]       reg_addr_i,
    input logic [TMO_W-1:0] reg_wdata_i,
    input logic             pwr_en_o,
    input logic             flash_sel_o,
    input logic             armed_o,
    input logic             busy_o,
    input logic             failover_o,
    input logic             error_o
);
    a_r4_busy_power_off: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !pwr_en_o);

    a_r4_start_drops_power: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !pwr_en_o && !armed_o);

    a_r5_swap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        ($rose(flash_sel_o) && busy_o) |-> failover_o && !pwr_en_o);

    a_r6_end_rearms: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> armed_o && pwr_en_o);

    a_r7_no_arm_in_recovery: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !armed_o);

    a_r8_failover_sticky: assert property (@(posedge clk) disable iff (rst)
        (failover_o && !(reg_we_i && reg_addr_i == ADDR_CTRL && reg_wdata_i[1]))
        |=> failover_o);

    a_r9_no_second_swap: assert property (@(posedge clk) disable iff (rst)
        $rose(error_o) |-> $stable(flash_sel_o) && pwr_en_o && !busy_o && !armed_o);

    a_r10_sel_needs_write: assert property (@(posedge clk) disable iff (rst)
        (!$stable(flash_sel_o) && !$past(busy_o))
        |-> ($past(reg_we_i) && $past(reg_addr_i) == ADDR_FSEL));
endmodule

bind boot_failover_wdog bfw_checker #(.TMO_W(TMO_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .pwr_en_o    (pwr_en_o),
    .flash_sel_o (flash_sel_o),
    .armed_o     (armed_o),
    .busy_o      (busy_o),
    .failover_o  (failover_o),
    .error_o     (error_o)
);

// File: tb/boot_failover_wdog_tb_top.sv
module boot_failover_wdog_tb_top;
    localparam int NS  = 3;
    localparam int TW  = 16;
    localparam int TR  = 20;
    localparam int P   = 4;
    localparam int OFF = 3;
    localparam int SET = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [NS-1:0] src;
    logic          we;
    logic [1:0]    addr;
    logic [TW-1:0] wdata;
    logic          pwr_en, fsel, armed, busy, failover, error_f;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    boot_failover_wdog #(
        .NUM_SRC(NS), .TMO_W(TW), .TMO_RESET(TR), .PRESCALE(P),
        .OFF_TICKS(OFF), .SETTLE_TICKS(SET)
    ) dut_i (
        .clk(clk), .rst(rst), .rst_src_i(src), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .pwr_en_o(pwr_en), .flash_sel_o(fsel), .armed_o(armed),
        .busy_o(busy), .failover_o(failover), .error_o(error_f)
    );

    function automatic int t_expire(int t);
        return t * P;
    endfunction
    function automatic int t_off();
        return OFF * P;
    endfunction
    function automatic int t_settle();
        return SET * P;
    endfunction

    task automatic chk(string req, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, int d);
        we = 1'b1; addr = a; wdata = TW'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic arm(int k);
        src[k] = 1'b1;
        @(negedge clk);
        src[k] = 1'b0;
    endtask

    // Entry: expiry lies t*P edges ahead. Returns one edge after power-on.
    task automatic check_seq(int t, string tag);
        step(t_expire(t) - 1);
        chk({tag, " R2 power before expiry"}, pwr_en, 1);
        chk({tag, " R2 armed before expiry"}, armed, 1);
        step(1);
        chk({tag, " R4 power off at expiry"}, pwr_en, 0);
        chk({tag, " R4 busy at expiry"}, busy, 1);
        step(t_off() - 1);
        chk({tag, " R4 select held during off"}, fsel, 0);
        step(1);
        chk({tag, " R5 select secondary"}, fsel, 1);
        chk({tag, " R5 failover flag"}, failover, 1);
        chk({tag, " R5 power still off"}, pwr_en, 0);
        step(t_settle() - 1);
        chk({tag, " R5 power held through settle"}, pwr_en, 0);
        step(1);
        chk({tag, " R6 power back on"}, pwr_en, 1);
        chk({tag, " R6 busy clear"}, busy, 0);
        chk({tag, " R6 rearmed"}, armed, 1);
    endtask

    task automatic clean();
        wr(2'd0, 7);
        wr(2'd2, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired, run hung");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1; src = '0; we = 1'b0; addr = '0; wdata = '0;
        step(3);
        chk("R1 power", pwr_en, 1);
        chk("R1 select", fsel, 0);
        chk("R1 armed", armed, 1);
        chk("R1 busy", busy, 0);
        chk("R1 failover", failover, 0);
        chk("R1 error", error_f, 0);
        rst = 1'b0;

        // R11 reset timeout drives the first failover
        check_seq(TR, "R11 reset-timeout");

        // R9 second expiry on secondary flash
        step(t_expire(TR) - 1);
        chk("R9 no error yet", error_f, 0);
        step(1);
        chk("R9 error set", error_f, 1);
        chk("R9 power stays on", pwr_en, 1);
        chk("R9 no swap back", fsel, 1);
        chk("R9 disarmed", armed, 0);
        chk("R9 not busy", busy, 0);

        // R8 sticky flags cleared only by their own bits
        step(5);
        chk("R8 failover held", failover, 1);
        wr(2'd0, 2);
        chk("R8 failover cleared", failover, 0);
        chk("R8 error kept", error_f, 1);
        wr(2'd0, 4);
        chk("R8 error cleared", error_f, 0);

        // R10 select write while idle
        wr(2'd2, 0);
        chk("R10 write primary", fsel, 0);

        // R7 and R10: stimulus during recovery is ignored
        wr(2'd1, 2);
        arm(0);
        step(t_expire(2));
        chk("R7 recovery started", busy, 1);
        arm(1);
        step(t_off() - 2);
        chk("R7 select still primary", fsel, 0);
        step(1);
        chk("R7 swap on schedule", fsel, 1);
        wr(2'd2, 0);
        step(t_settle() - 1);
        chk("R7 power on schedule", pwr_en, 1);
        chk("R10 write in recovery ignored", fsel, 1);
        chk("R7 rearmed at power-on", armed, 1);
        clean();

        // R11 zero timeout stored as one tick
        wr(2'd1, 0);
        arm(2);
        check_seq(1, "R11 zero");
        clean();

        // R11 new value waits for next load
        wr(2'd1, 6);
        arm(2);
        wr(2'd1, 2);
        step(t_expire(6) - 2);
        chk("R11 old value kept", pwr_en, 1);
        step(1);
        chk("R11 expiry at old value", pwr_en, 0);
        step(t_off() + t_settle());
        chk("R11 sequence done", pwr_en, 1);
        clean();

        // R12 and R2: re-arm while armed restarts count and phase
        wr(2'd1, 5);
        arm(0);
        step(3 * P + 1);
        arm(1);
        check_seq(5, "R12 rearm");
        clean();

        // R3 disarm on the very expiry edge
        wr(2'd1, 3);
        arm(1);
        step(t_expire(3) - 1);
        wr(2'd0, 1);
        step(t_expire(3) + 8);
        chk("R3 disarm at last edge", pwr_en, 1);
        chk("R3 disarmed", armed, 0);

        // random mix
        for (int i = 0; i < 24; i++) begin
            int t;
            int k;
            t = 1 + int'($urandom % 8);
            k = int'($urandom % NS);
            wr(2'd1, t);
            arm(k);
            if ($urandom % 2 == 0) begin
                int d;
                d = int'($urandom % t_expire(t));
                step(d);
                wr(2'd0, 1);
                step(t_expire(t) + 6);
                chk("R3 random disarm power", pwr_en, 1);
                chk("R3 random disarm armed", armed, 0);
                chk("R3 random disarm select", fsel, 0);
            end else begin
                check_seq(t, "R2 random");
                clean();
                chk("R8 random clear", failover, 0);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule